// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block holds the transmit and receive error counters of a CAN controller and derives the node's fault confinement state from them. The protocol engine reports error events as strobes. An increment strobe comes with a step size, because the protocol rules that choose the size sit outside this block. The state field reads error-active, error-passive or bus-off. When the transmit counter overflows, the block enters bus-off and raises a one-cycle interrupt pulse.

In bus-off the transmit counter is reused for recovery. A small run counter watches the sampled bus bits, and each run of 11 consecutive recessive bits advances the transmit counter by one. The 128th run ends bus-off and the node restarts as error-active with both counters cleared.

The CPU may overwrite both counters only while freeze mode is set. The write goes into an auxiliary register in the CPU clock domain. A toggle request then crosses into the protocol clock domain, and a toggle acknowledge returns. While the exchange is in flight, a pending flag tells software that the new values have not yet landed.

Top module: `can_fault_confine`

## Requirements
- R1: After reset both counters read 0, the state field reads 2'b00, the interrupt is low and the pending flag is low.
- R2: A CPU write while freeze mode is low is ignored: the pending flag stays low and both counters keep their values.
- R3: The state field reads 2'b01 (error-passive) whenever either counter is at 128 or above outside bus-off, and 2'b00 (error-active) otherwise.
- R4: From error-passive, the state returns to 2'b00 only once both counters are at 127 or below.
- R5: A CPU write in freeze mode carries the transmit value in data bits 15:8 and the receive value in bits 7:0. The pending flag is high from the CPU cycle after the write until the acknowledge returns, and the counters hold the written values by the time the flag falls.
- R6: An increment strobe adds its step to its counter. A decrement strobe subtracts one and stops at 0. The receive counter stops at 255.
- R7: A transmit increment that would pass 255 sets the state to 2'b10 (bus-off), clears the transmit counter, and pulses the bus-off interrupt for exactly one protocol cycle.
- R8: Error event strobes have no effect on either counter while in bus-off.
- R9: In bus-off, a dominant sample restarts the recessive-run count, and every run of 11 recessive samples adds one to the transmit counter.
- R10: The 128th recessive run ends bus-off: both counters clear and the state returns to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| canClk | input | 1 | Protocol clock |
| canRstN | input | 1 | Protocol-domain reset, active low |
| cpuClk | input | 1 | CPU clock |
| cpuRstN | input | 1 | CPU-domain reset, active low |
| freezeMode | input | 1 | Freeze mode flag (CPU domain), enables counter writes |
| cpuWrEn | input | 1 | CPU write strobe for the counters |
| cpuWrData | input | 16 | Write data: [15:8] transmit, [7:0] receive |
| cpuWrPending | output | 1 | Write accepted but not yet applied to the counters |
| txErrInc | input | 1 | Transmit error increment strobe |
| txIncStep | input | 4 | Step size for the transmit increment |
| txErrDec | input | 1 | Transmit error decrement strobe |
| rxErrInc | input | 1 | Receive error increment strobe |
| rxIncStep | input | 4 | Step size for the receive increment |
| rxErrDec | input | 1 | Receive error decrement strobe |
| rxBitValid | input | 1 | One strobe per sampled bus bit |
| rxBitRecessive | input | 1 | Sampled bit is recessive |
| txErrCnt | output | 8 | Transmit error counter |
| rxErrCnt | output | 8 | Receive error counter |
| faultState | output | 2 | 00 error-active, 01 error-passive, 1x bus-off |
| busOffIrq | output | 1 | One-cycle pulse on entry to bus-off |

## Verification
The hardest condition to reach is the end of bus-off recovery. It needs the node in bus-off with a receive count that is not zero, and then 128 complete recessive runs. The stimulus first loads the counters through a freeze-mode write, with the transmit counter near its limit and a small receive value. One large increment then forces the overflow. The bench next sends an interrupted run that a dominant bit breaks off, and after that it streams whole runs while it checks the transmit counter at run 127 and at run 128.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fcState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;         // apply CPU value to both counters
    logic evtEnable;    // error events may move the counters
    logic enterBusOff;  // clear transmit counter on overflow
    logic recCount;     // one more recessive run seen in bus-off
    logic clearAll;     // recovery complete, clear both counters
  } fcStrb_t;

endpackage

// File: rtl/can_fc_wr_bridge.sv
module can_fc_wr_bridge #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               cpuClk,
  input  logic               cpuRstN,
  input  logic               canClk,
  input  logic               canRstN,
  input  logic               freezeMode,
  input  logic               wrEn,
  input  logic [2*CNT_W-1:0] wrData,
  output logic               pending,
  output logic               loadPulse,
  output logic [2*CNT_W-1:0] loadData
);

  logic               reqTgl;
  logic [2*CNT_W-1:0] auxData;
  logic [SYNC_STAGES-1:0] ackSync;
  logic [SYNC_STAGES-1:0] reqSync;
  logic               reqSeen;
  logic               ackTgl;

  assign pending = reqTgl ^ ackSync[SYNC_STAGES-1];

  // CPU side: hold the data and flip the request
  always_ff @(posedge cpuClk or negedge cpuRstN) begin
    if (!cpuRstN) begin
      reqTgl  <= 1'b0;
      auxData <= '0;
      ackSync <= '0;
    end else begin
      ackSync <= {ackSync[SYNC_STAGES-2:0], ackTgl};
      if (wrEn && freezeMode && !pending) begin
        auxData <= wrData;
        reqTgl  <= ~reqTgl;
      end
    end
  end

  // protocol side: detect the request edge, echo it back as acknowledge
  always_ff @(posedge canClk or negedge canRstN) begin
    if (!canRstN) begin
      reqSync <= '0;
      reqSeen <= 1'b0;
    end else begin
      reqSync <= {reqSync[SYNC_STAGES-2:0], reqTgl};
      reqSeen <= reqSync[SYNC_STAGES-1];
    end
  end

  assign ackTgl    = reqSeen;
  assign loadPulse = reqSync[SYNC_STAGES-1] ^ reqSeen;
  assign loadData  = auxData;

endmodule

// File: rtl/can_fc_dpath.sv
module can_fc_dpath
  import can_fc_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int STEP_W = 4
) (
  input  logic              canClk,
  input  logic              canRstN,
  input  fcStrb_t           strb,
  input  logic [CNT_W-1:0]  loadTx,
  input  logic [CNT_W-1:0]  loadRx,
  input  logic              txInc,
  input  logic [STEP_W-1:0] txStep,
  input  logic              txDec,
  input  logic              rxInc,
  input  logic [STEP_W-1:0] rxStep,
  input  logic              rxDec,
  output logic [CNT_W-1:0]  txCnt,
  output logic [CNT_W-1:0]  rxCnt,
  output logic              txOverflow
);

  localparam int SUM_W = CNT_W + 1;
  localparam logic [SUM_W-1:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [SUM_W-1:0] txSum;
  logic [SUM_W-1:0] rxSum;
  logic [CNT_W-1:0] txNext;
  logic [CNT_W-1:0] rxNext;

  assign txSum      = {1'b0, txCnt} + SUM_W'(txStep);
  assign rxSum      = {1'b0, rxCnt} + SUM_W'(rxStep);
  assign txOverflow = txInc && (txSum > CNT_MAX);

  always_comb begin
    txNext = txCnt;
    if (strb.load) begin
      txNext = loadTx;
    end else if (strb.clearAll || strb.enterBusOff) begin
      txNext = '0;
    end else if (strb.recCount) begin
      txNext = txCnt + CNT_W'(1);
    end else if (strb.evtEnable) begin
      if (txInc) begin
        txNext = txSum[CNT_W-1:0];
      end else if (txDec && (txCnt != '0)) begin
        txNext = txCnt - CNT_W'(1);
      end
    end
  end

  always_comb begin
    rxNext = rxCnt;
    if (strb.load) begin
      rxNext = loadRx;
    end else if (strb.clearAll) begin
      rxNext = '0;
    end else if (strb.evtEnable) begin
      if (rxInc) begin
        rxNext = (rxSum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : rxSum[CNT_W-1:0];
      end else if (rxDec && (rxCnt != '0)) begin
        rxNext = rxCnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge canClk or negedge canRstN) begin
    if (!canRstN) begin
      txCnt <= '0;
      rxCnt <= '0;
    end else begin
      txCnt <= txNext;
      rxCnt <= rxNext;
    end
  end

endmodule

// File: rtl/can_fc_ctrl.sv
module can_fc_ctrl
  import can_fc_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int RUN_LEN    = 11,
  parameter int SEQ_TARGET = 128
) (
  input  logic             canClk,
  input  logic             canRstN,
  input  logic             loadPulse,
  input  logic [CNT_W-1:0] txCnt,
  input  logic [CNT_W-1:0] rxCnt,
  input  logic             txOverflow,
  input  logic             rxBitValid,
  input  logic             rxBitRecessive,
  output fcStrb_t          strb,
  output logic [1:0]       faultState,
  output logic             busOffIrq
);

  localparam int RUN_W = $clog2(RUN_LEN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [CNT_W-1:0] SEQ_LAST = CNT_W'(SEQ_TARGET - 1);

  logic             busOff;
  logic [RUN_W-1:0] recRun;
  logic             runDone;
  logic             recoverNow;
  fcState_e         stateNow;

  assign runDone    = busOff && rxBitValid && rxBitRecessive && (recRun == RUN_LAST);
  assign recoverNow = runDone && (txCnt == SEQ_LAST);

  always_comb begin
    strb.load        = loadPulse;
    strb.evtEnable   = !busOff;
    strb.enterBusOff = !busOff && txOverflow && !loadPulse;
    strb.recCount    = runDone && !recoverNow && !loadPulse;
    strb.clearAll    = recoverNow && !loadPulse;
  end

  always_ff @(posedge canClk or negedge canRstN) begin
    if (!canRstN) begin
      busOff    <= 1'b0;
      busOffIrq <= 1'b0;
      recRun    <= '0;
    end else begin
      busOffIrq <= strb.enterBusOff;
      if (strb.enterBusOff) begin
        busOff <= 1'b1;
      end else if (strb.clearAll) begin
        busOff <= 1'b0;
      end
      if (!busOff || (rxBitValid && !rxBitRecessive)) begin
        recRun <= '0;
      end else if (rxBitValid) begin
        recRun <= (recRun == RUN_LAST) ? '0 : recRun + RUN_W'(1);
      end
    end
  end

  always_comb begin
    if (busOff) begin
      stateNow = FC_BUSOFF;
    end else if (txCnt[CNT_W-1] || rxCnt[CNT_W-1]) begin
      stateNow = FC_PASSIVE;
    end else begin
      stateNow = FC_ACTIVE;
    end
  end

  assign faultState = stateNow;

endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
  import can_fc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int STEP_W      = 4,
  parameter int RUN_LEN     = 11,
  parameter int SEQ_TARGET  = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic               canClk,
  input  logic               canRstN,
  input  logic               cpuClk,
  input  logic               cpuRstN,
  input  logic               freezeMode,
  input  logic               cpuWrEn,
  input  logic [2*CNT_W-1:0] cpuWrData,
  output logic               cpuWrPending,
  input  logic               txErrInc,
  input  logic [STEP_W-1:0]  txIncStep,
  input  logic               txErrDec,
  input  logic               rxErrInc,
  input  logic [STEP_W-1:0]  rxIncStep,
  input  logic               rxErrDec,
  input  logic               rxBitValid,
  input  logic               rxBitRecessive,
  output logic [CNT_W-1:0]   txErrCnt,
  output logic [CNT_W-1:0]   rxErrCnt,
  output logic [1:0]         faultState,
  output logic               busOffIrq
);

  logic               loadPulse;
  logic [2*CNT_W-1:0] loadData;
  logic               txOverflow;
  fcStrb_t            ctrlStrb;

  can_fc_wr_bridge #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) bridge_i (
    .cpuClk    (cpuClk),
    .cpuRstN   (cpuRstN),
    .canClk    (canClk),
    .canRstN   (canRstN),
    .freezeMode(freezeMode),
    .wrEn      (cpuWrEn),
    .wrData    (cpuWrData),
    .pending   (cpuWrPending),
    .loadPulse (loadPulse),
    .loadData  (loadData)
  );

  can_fc_ctrl #(.CNT_W(CNT_W), .RUN_LEN(RUN_LEN), .SEQ_TARGET(SEQ_TARGET)) ctrl_i (
    .canClk        (canClk),
    .canRstN       (canRstN),
    .loadPulse     (loadPulse),
    .txCnt         (txErrCnt),
    .rxCnt         (rxErrCnt),
    .txOverflow    (txOverflow),
    .rxBitValid    (rxBitValid),
    .rxBitRecessive(rxBitRecessive),
    .strb          (ctrlStrb),
    .faultState    (faultState),
    .busOffIrq     (busOffIrq)
  );

  can_fc_dpath #(.CNT_W(CNT_W), .STEP_W(STEP_W)) dpath_i (
    .canClk    (canClk),
    .canRstN   (canRstN),
    .strb      (ctrlStrb),
    .loadTx    (loadData[2*CNT_W-1:CNT_W]),
    .loadRx    (loadData[CNT_W-1:0]),
    .txInc     (txErrInc),
    .txStep    (txIncStep),
    .txDec     (txErrDec),
    .rxInc     (rxErrInc),
    .rxStep    (rxIncStep),
    .rxDec     (rxErrDec),
    .txCnt     (txErrCnt),
    .rxCnt     (rxErrCnt),
    .txOverflow(txOverflow)
  );

endmodule

// File: rtl/can_fault_confine_chk.sv
module can_fault_confine_chk #(
  parameter int CNT_W = 8
) (
  input logic             canClk,
  input logic             canRstN,
  input logic [CNT_W-1:0] txErrCnt,
  input logic [CNT_W-1:0] rxErrCnt,
  input logic [1:0]       faultState,
  input logic             busOffIrq,
  input logic             loadPulse
);

  localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);

  // R7: interrupt lasts a single cycle
  a_r7_irq_single: assert property (@(posedge canClk) disable iff (!canRstN)
    busOffIrq |=> !busOffIrq);

  // R7: interrupt coincides with bus-off and a cleared transmit counter
  a_r7_irq_entry: assert property (@(posedge canClk) disable iff (!canRstN)
    busOffIrq |-> (faultState[1] && (txErrCnt == '0)));

  // R4: leaving error-passive for error-active needs both counters below half
  a_r4_exit_passive: assert property (@(posedge canClk) disable iff (!canRstN)
    ($fell(faultState[0]) && !faultState[1]) |-> ((txErrCnt < HALF) && (rxErrCnt < HALF)));

  // R8: receive counter frozen while in bus-off unless recovery clears it
  a_r8_rx_frozen: assert property (@(posedge canClk) disable iff (!canRstN)
    (faultState[1] && !loadPulse) |=> ($stable(rxErrCnt) || (faultState == 2'b00)));

  // R9: in bus-off the transmit counter advances by at most one per cycle
  a_r9_tx_step: assert property (@(posedge canClk) disable iff (!canRstN)
    (faultState[1] && !loadPulse) |=>
      ((txErrCnt == $past(txErrCnt)) || (txErrCnt == $past(txErrCnt) + CNT_W'(1)) ||
       (faultState == 2'b00)));

endmodule

bind can_fault_confine can_fault_confine_chk #(.CNT_W(CNT_W)) chk_i (
  .canClk    (canClk),
  .canRstN   (canRstN),
  .txErrCnt  (txErrCnt),
  .rxErrCnt  (rxErrCnt),
  .faultState(faultState),
  .busOffIrq (busOffIrq),
  .loadPulse (loadPulse)
);

// File: tb/can_fault_confine_tb.sv
`timescale 1ns/1ps
module can_fault_confine_tb_top;

  logic        canClk = 1'b0;
  logic        cpuClk = 1'b0;
  logic        canRstN = 1'b0;
  logic        cpuRstN = 1'b0;
  logic        freezeMode = 1'b0;
  logic        cpuWrEn = 1'b0;
  logic [15:0] cpuWrData = '0;
  logic        cpuWrPending;
  logic        txErrInc = 1'b0;
  logic [3:0]  txIncStep = '0;
  logic        txErrDec = 1'b0;
  logic        rxErrInc = 1'b0;
  logic [3:0]  rxIncStep = '0;
  logic        rxErrDec = 1'b0;
  logic        rxBitValid = 1'b0;
  logic        rxBitRecessive = 1'b0;
  logic [7:0]  txErrCnt;
  logic [7:0]  rxErrCnt;
  logic [1:0]  faultState;
  logic        busOffIrq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 cpuClk = ~cpuClk;   // 100 MHz
  always #8 canClk = ~canClk;   // protocol clock, unrelated to the CPU clock

  can_fault_confine dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic canEvt(input logic ti, input int ts, input logic td,
                        input logic ri, input int rs, input logic rd);
    @(negedge canClk);
    txErrInc = ti; txIncStep = 4'(ts); txErrDec = td;
    rxErrInc = ri; rxIncStep = 4'(rs); rxErrDec = rd;
    @(negedge canClk);
    txErrInc = 1'b0; txErrDec = 1'b0; rxErrInc = 1'b0; rxErrDec = 1'b0;
  endtask

  task automatic sendBit(input logic recessive);
    @(negedge canClk);
    rxBitValid = 1'b1; rxBitRecessive = recessive;
    @(negedge canClk);
    rxBitValid = 1'b0;
  endtask

  task automatic cpuWrite(input logic frz, input logic [15:0] data);
    @(negedge cpuClk);
    freezeMode = frz; cpuWrEn = 1'b1; cpuWrData = data;
    @(negedge cpuClk);
    cpuWrEn = 1'b0;
  endtask

  task automatic waitPending();
    for (int i = 0; i < 100 && cpuWrPending; i++) @(negedge cpuClk);
    repeat (2) @(negedge canClk);
  endtask

  task automatic testReset();
    check("R1 tx", txErrCnt, 0);
    check("R1 rx", rxErrCnt, 0);
    check("R1 state", faultState, 0);
    check("R1 irq", busOffIrq, 0);
    check("R1 pending", cpuWrPending, 0);
  endtask

  task automatic testPassiveAndBack();
    for (int i = 0; i < 15; i++) canEvt(1, 8, 0, 0, 0, 0);
    check("R6 tx sum", txErrCnt, 120);
    check("R3 active at 120", faultState, 0);
    canEvt(1, 8, 0, 0, 0, 0);
    check("R3 passive tx 128", faultState, 1);
    canEvt(0, 0, 1, 0, 0, 0);
    check("R4 active tx 127", faultState, 0);
    for (int i = 0; i < 17; i++) canEvt(0, 0, 0, 1, 8, 0);
    check("R3 passive rx 136", faultState, 1);
    canEvt(0, 0, 1, 0, 0, 0);
    check("R4 still passive", faultState, 1);
    for (int i = 0; i < 9; i++) canEvt(0, 0, 0, 0, 0, 1);
    check("R4 rx 127", rxErrCnt, 127);
    check("R4 back active", faultState, 0);
  endtask

  task automatic testSaturate();
    for (int i = 0; i < 130; i++) canEvt(0, 0, 1, 0, 0, 0);
    check("R6 tx floor", txErrCnt, 0);
    for (int i = 0; i < 10; i++) canEvt(0, 0, 0, 1, 15, 0);
    check("R6 rx ceiling", rxErrCnt, 255);
    check("R3 passive rx 255", faultState, 1);
  endtask

  task automatic testWrites();
    cpuWrite(1'b0, 16'h1234);
    check("R2 no pending", cpuWrPending, 0);
    repeat (8) @(negedge canClk);
    check("R2 tx kept", txErrCnt, 0);
    check("R2 rx kept", rxErrCnt, 255);
    cpuWrite(1'b1, 16'hFA05);
    check("R5 pending high", cpuWrPending, 1);
    waitPending();
    check("R5 pending low", cpuWrPending, 0);
    check("R5 tx loaded", txErrCnt, 250);
    check("R5 rx loaded", rxErrCnt, 5);
    freezeMode = 1'b0;
  endtask

  task automatic testBusOff();
    @(negedge canClk);
    txErrInc = 1'b1; txIncStep = 4'd8;
    @(negedge canClk);
    txErrInc = 1'b0;
    check("R7 state busoff", faultState, 2);
    check("R7 tx cleared", txErrCnt, 0);
    check("R7 irq", busOffIrq, 1);
    @(negedge canClk);
    check("R7 irq one cycle", busOffIrq, 0);
    canEvt(1, 5, 0, 1, 3, 0);
    canEvt(0, 0, 1, 0, 0, 1);
    check("R8 tx ignored", txErrCnt, 0);
    check("R8 rx ignored", rxErrCnt, 5);
  endtask

  task automatic testRecovery();
    for (int i = 0; i < 10; i++) sendBit(1'b1);
    sendBit(1'b0);
    check("R9 broken run", txErrCnt, 0);
    for (int i = 0; i < 11; i++) sendBit(1'b1);
    check("R9 one run", txErrCnt, 1);
    for (int r = 0; r < 126; r++)
      for (int i = 0; i < 11; i++) sendBit(1'b1);
    check("R9 run 127", txErrCnt, 127);
    check("R10 still busoff", faultState, 2);
    for (int i = 0; i < 11; i++) sendBit(1'b1);
    check("R10 active", faultState, 0);
    check("R10 tx clear", txErrCnt, 0);
    check("R10 rx clear", rxErrCnt, 0);
  endtask

  always @(posedge canClk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge canClk);
    canRstN = 1'b1;
    cpuRstN = 1'b1;
    @(negedge canClk);
    testReset();
    testPassiveAndBack();
    testSaturate();
    testWrites();
    testBusOff();
    testRecovery();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule